// File: doc/BRIEF.md
# Dual 8-bit / Chained 16-bit Event Counter

This block counts rising edges on two asynchronous event inputs. It has two 8-bit counter halves. A mode bit in the control register sets how they work. With the bit at 0, the halves form one 16-bit counter: the low half counts edges from the low event input, and the high half advances on each carry out of the low half. With the bit at 1, each half counts edges from its own input as a separate 8-bit counter.

Each half has two control bits. A run bit holds the half at zero while it is 0. An enable bit freezes the count while it is 0. Overflows set sticky flags and a shared interrupt-request flag, which raises the interrupt output when the interrupt enable bit is set. Software reaches the controls, the flags and both counts through a small single-cycle register port. Reads are combinational and writes take effect at the clock edge.

Top module: `evcnt_dual`

## Requirements
- R1: After reset, every register bit reads 0 and the interrupt output is low. The mode bit at 0 means the counter starts in chained 16-bit mode, and both counts are held at zero.
- R2: In chained mode (control bit 0 = 0), the low half counts low-input edges. The high half advances by one when the low half wraps from 0xFF. Edges on the high input have no effect.
- R3: In chained mode, an event while the pair holds 0xFFFF makes the pair read 0x0000. It also sets the high overflow flag (control bit 6) and leaves the low overflow flag unchanged. Counting then continues from zero.
- R4: In split mode (control bit 0 = 1), the low half counts low-input edges and the high half counts high-input edges, each independently.
- R5: In split mode, a half wrapping from 0xFF to 0x00 sets only its own overflow flag: control bit 5 for the low half, bit 6 for the high half.
- R6: While a half's run bit is 0, that half reads 0x00. The low run bit is control bit 3 and the high run bit is control bit 4.
- R7: While a half's enable bit is 0, its count stays unchanged. The low enable bit is control bit 1 and the high enable bit is control bit 2.
- R8: A rising edge first sampled high at clock edge k changes the count at clock edge k+2. An input held high counts once. The count advances by at most one per clock.
- R9: Any overflow sets the interrupt-request flag (address 1, bit 0). The interrupt output equals that flag ANDed with the interrupt enable bit (control bit 7).
- R10: Overflow flags and the interrupt-request flag stay set until software writes 0 to their bit. Writing 1 has no effect. An overflow in the same cycle as a clearing write leaves the flag set.
- R11: Address 0 is the control/status register. Address 1 holds the interrupt-request flag, and its other bits read 0. Address 2 reads the low count and address 3 the high count. Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_lo_in | input | 1 | Asynchronous event input for the low half |
| ev_hi_in | input | 1 | Asynchronous event input for the high half (split mode only) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the chained counter through all 65536 events to reach the 0xFFFF wrap. A design that carried at the wrong place, or that flagged the low half in chained mode, would show a wrong high count or a stray low overflow flag. A clearing write is timed to land on the same edge as a split-mode low wrap, so a design in which the clear won would drop the flag. The bench also holds an input high for several cycles and toggles it every cycle. A design without proper edge detection or synchronizer latency would count too often or in the wrong cycle. High-input pulses in chained mode, writes to the count addresses, and writes of 1 to the flag bits must leave the read-back values unchanged.

// File: rtl/evcnt_dual.sv
module evcnt_dual #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_lo_in,
  input  logic         ev_hi_in,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  logic [2:0]   sync_lo, sync_hi;
  logic         split, en_lo, en_hi, run_lo, run_hi;
  logic         ovf_lo, ovf_hi, irq_en, irq_flag;
  logic [W-1:0] cnt_lo, cnt_hi;

  wire edge_lo = sync_lo[1] & ~sync_lo[2];
  wire edge_hi = sync_hi[1] & ~sync_hi[2];

  wire inc_lo   = run_lo & en_lo & edge_lo;
  wire carry_lo = inc_lo & (&cnt_lo);
  wire inc_hi   = run_hi & en_hi & (split ? edge_hi : carry_lo);
  wire wrap_hi  = inc_hi & (&cnt_hi);
  wire set_lo   = split & carry_lo;
  wire set_any  = set_lo | wrap_hi;

  wire wr_ctl = wr_en && addr == 2'd0;
  wire wr_irq = wr_en && addr == 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_lo <= '0;
      sync_hi <= '0;
    end else begin
      sync_lo <= {sync_lo[1:0], ev_lo_in};
      sync_hi <= {sync_hi[1:0], ev_hi_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      if (!run_lo)     cnt_lo <= '0;
      else if (inc_lo) cnt_lo <= cnt_lo + 1'b1;
      if (!run_hi)     cnt_hi <= '0;
      else if (inc_hi) cnt_hi <= cnt_hi + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {irq_en, run_hi, run_lo, en_hi, en_lo, split} <= '0;
      ovf_lo   <= 1'b0;
      ovf_hi   <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (wr_ctl) begin
        split  <= wdata[0];
        en_lo  <= wdata[1];
        en_hi  <= wdata[2];
        run_lo <= wdata[3];
        run_hi <= wdata[4];
        irq_en <= wdata[7];
      end
      ovf_lo   <= set_lo  | (ovf_lo   & ~(wr_ctl & ~wdata[5]));
      ovf_hi   <= wrap_hi | (ovf_hi   & ~(wr_ctl & ~wdata[6]));
      irq_flag <= set_any | (irq_flag & ~(wr_irq & ~wdata[0]));
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata[7:0] = {irq_en, ovf_hi, ovf_lo, run_hi, run_lo, en_hi, en_lo, split};
      2'd1: rdata[0]   = irq_flag;
      2'd2: rdata      = cnt_lo;
      default: rdata   = cnt_hi;
    endcase
  end

  assign irq = irq_flag & irq_en;
endmodule

module evcnt_dual_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic         split,
  input logic         en_lo,
  input logic         en_hi,
  input logic         run_lo,
  input logic         run_hi,
  input logic         edge_lo,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         ovf_lo,
  input logic         ovf_hi,
  input logic         irq_flag
);
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lo |=> cnt_lo == '0);

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_lo && !en_lo |=> cnt_lo == $past(cnt_lo));

  p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_lo |=> (cnt_lo == $past(cnt_lo) || cnt_lo == W'($past(cnt_lo) + 1'b1)));

  p_chain_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !split && run_lo && en_lo && run_hi && en_hi && edge_lo && (&cnt_lo) && (&cnt_hi)
    |=> ovf_hi && cnt_lo == '0 && cnt_hi == '0);

  p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hi && !(wr_en && addr == 2'd0 && !wdata[6]) |=> ovf_hi);

  p_flag_raises_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_lo) || $rose(ovf_hi) |-> irq_flag);
endmodule

bind evcnt_dual evcnt_dual_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .split(split), .en_lo(en_lo), .en_hi(en_hi), .run_lo(run_lo), .run_hi(run_hi),
  .edge_lo(edge_lo), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .irq_flag(irq_flag)
);

// File: tb/evcnt_dual_test.sv
`timescale 1ns/1ps
module evcnt_dual_test;
  typedef struct {
    bit       l;
    bit       h;
    bit       w;
    bit [1:0] a;
    bit [7:0] d;
  } cmd_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       lo_in = 0, hi_in = 0, we = 0;
  logic [1:0] a = 0;
  logic [7:0] d = 0;
  logic [7:0] rdata;
  logic       irq;

  cmd_t  cmdq[$];
  string tagq[$];
  string cur_tag = "R1";
  int    checks = 0, errors = 0;
  int    rot = 0;
  bit    done = 0;

  int m_lo, m_hi;
  bit m_split, m_enl, m_enh, m_runl, m_runh, m_ovl, m_ovh, m_ien, m_if;
  bit [2:0] m_sl, m_sh;

  always #10 clk = ~clk;

  evcnt_dual #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .ev_lo_in(lo_in), .ev_hi_in(hi_in),
    .wr_en(we), .addr(a), .wdata(d), .rdata(rdata), .irq(irq)
  );

  function automatic int model_read(input int ad);
    case (ad)
      0: return {m_ien, m_ovh, m_ovl, m_runh, m_runl, m_enh, m_enl, m_split};
      1: return {7'b0, m_if};
      2: return m_lo;
      default: return m_hi;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_sl = 0; m_sh = 0; m_if = 0;
      {m_ien, m_ovh, m_ovl, m_runh, m_runl, m_enh, m_enl, m_split} = 8'h00;
    end else begin
      bit el, eh, cl, ch, fl, fh;
      el = m_sl[1] && !m_sl[2];
      eh = m_sh[1] && !m_sh[2];
      m_sl = {m_sl[1:0], lo_in};
      m_sh = {m_sh[1:0], hi_in};
      cl = m_runl && m_enl && el;
      ch = m_runh && m_enh && (m_split ? eh : (cl && m_lo == 255));
      fl = m_split && cl && m_lo == 255;
      fh = ch && m_hi == 255;
      if (!m_runl) m_lo = 0; else if (cl) m_lo = (m_lo + 1) % 256;
      if (!m_runh) m_hi = 0; else if (ch) m_hi = (m_hi + 1) % 256;
      if (we && a == 0 && !d[5]) m_ovl = 0;
      if (we && a == 0 && !d[6]) m_ovh = 0;
      if (we && a == 1 && !d[0]) m_if = 0;
      if (fl) m_ovl = 1;
      if (fh) m_ovh = 1;
      if (fl || fh) m_if = 1;
      if (we && a == 0) begin
        m_split = d[0]; m_enl = d[1]; m_enh = d[2];
        m_runl = d[3]; m_runh = d[4]; m_ien = d[7];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_r;
      exp_r = model_read(a);
      checks++;
      if (rdata !== exp_r[7:0]) begin
        errors++;
        $display("FAIL %s: addr %0d rdata %h expected %h", cur_tag, a, rdata, exp_r[7:0]);
      end
      checks++;
      if (irq !== (m_if && m_ien)) begin
        errors++;
        $display("FAIL %s: irq %b expected %b", cur_tag, irq, m_if && m_ien);
      end
    end
    if (cmdq.size() > 0) begin
      cmd_t c;
      c = cmdq.pop_front();
      cur_tag = tagq.pop_front();
      lo_in = c.l; hi_in = c.h; we = c.w; a = c.a; d = c.d;
    end else begin
      lo_in = 0; hi_in = 0; we = 0; a = rot[1:0]; rot++;
    end
  end

  task automatic push(input bit l, input bit h, input bit w, input bit [1:0] ad,
                      input bit [7:0] dt, input string t);
    cmd_t c;
    c.l = l; c.h = h; c.w = w; c.a = ad; c.d = dt;
    cmdq.push_back(c);
    tagq.push_back(t);
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) push(0, 0, 0, 2'(i), 8'h00, t);
  endtask

  task automatic wr(input bit [1:0] ad, input bit [7:0] dt, input string t);
    push(0, 0, 1, ad, dt, t);
  endtask

  task automatic pulses(input int n, input bit l, input bit h, input string t);
    for (int i = 0; i < n; i++) begin
      push(l, h, 0, 2'(i), 8'h00, t);
      push(0, 0, 0, 2'(i + 1), 8'h00, t);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, queue %0d expected 0", cmdq.size());
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #3 rst_n = 1;
    idle(8, "R1");
    // R11: count addresses are read-only, address 1 write of 1 is inert
    wr(2, 8'h55, "R11"); wr(3, 8'hAA, "R11"); wr(1, 8'h01, "R11"); idle(4, "R11");
    // R6: enables on, run bits off
    wr(0, 8'h66, "R6"); pulses(5, 1, 1, "R6"); idle(4, "R6");
    // R2: chained counting across a low carry, high input ignored
    wr(0, 8'h7E, "R2"); pulses(300, 1, 0, "R2"); pulses(5, 0, 1, "R2"); idle(4, "R2");
    // R7: low enable off freezes
    wr(0, 8'h7C, "R7"); pulses(4, 1, 0, "R7"); wr(0, 8'h7E, "R7"); idle(4, "R7");
    // R8: held-high input counts once
    for (int i = 0; i < 6; i++) push(1, 0, 0, 2'd2, 8'h00, "R8");
    idle(6, "R8");
    // R3: full 16-bit wrap
    wr(0, 8'h66, "R3"); wr(0, 8'hFE, "R3");
    pulses(65536, 1, 0, "R3"); idle(6, "R3"); pulses(3, 1, 0, "R3"); idle(4, "R3");
    // R10: write 1 keeps, write 0 clears
    wr(0, 8'hFE, "R10"); idle(4, "R10");
    wr(0, 8'hBE, "R10"); wr(1, 8'h00, "R10"); idle(4, "R10");
    // R4 / R5: split mode
    wr(0, 8'h87, "R4"); wr(0, 8'h9F, "R4");
    pulses(20, 1, 1, "R4"); pulses(7, 1, 0, "R4"); idle(4, "R4");
    pulses(236, 0, 1, "R5"); idle(6, "R5");
    // R9: interrupt gating
    wr(0, 8'h7F, "R9"); idle(4, "R9"); wr(0, 8'hFF, "R9"); idle(4, "R9");
    // R10: overflow in the same cycle as a clearing write
    wr(0, 8'h9F, "R10"); wr(1, 8'h00, "R10");
    pulses(229, 1, 0, "R5"); idle(4, "R5");
    pulses(255, 1, 0, "R10");
    push(1, 0, 0, 2'd0, 8'h00, "R10");
    push(0, 0, 0, 2'd0, 8'h00, "R10");
    wr(0, 8'h9F, "R10");
    idle(8, "R10");
    wait (cmdq.size() == 0);
    repeat (8) @(negedge clk);
    #1 finish_run();
  end
endmodule